// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block lives in the decode stage of a five-stage, in-order pipeline. Each cycle it compares the two source register numbers of the instruction in decode with the destination register of the instruction in execute. It also looks at whether that execute-stage instruction reads memory. If a load in execute writes a register that decode is about to read, the value cannot be forwarded in time. The block then holds the front of the pipeline for one cycle.

A stall has three effects. The program counter write enable drops, so the same instruction is fetched again. The write enable of the fetch/decode pipeline register drops, so decode keeps its instruction. A select goes high, and the surrounding datapath uses it to replace the decode-stage control bundle with zeros as that bundle enters the execute register. The zeroed bundle moves down the pipeline as a no-op and writes nothing. One cycle later the load has moved on to the memory stage and execute holds the bubble, so the condition clears by itself. The dependent instruction then takes its operand from the existing forwarding path.

The unit is purely combinational. It holds no state and needs no clock or reset. Forwarding, the register file and the datapath are outside it.

Top module: `hzd_load_use_unit`

## Requirements
- R1: When `exe_mem_rd` is 1, `exe_dst` is nonzero and `exe_dst` equals `dec_src_a`, the unit signals a stall in the same cycle.
- R2: When `exe_mem_rd` is 1, `exe_dst` is nonzero and `exe_dst` equals `dec_src_b`, the unit signals a stall in the same cycle.
- R3: A load whose destination is register 0 (`exe_dst` = 0) never causes a stall, whatever the source numbers are.
- R4: When `exe_mem_rd` is 0 (the producer in execute is not a load), there is no stall, even if the register numbers match.
- R5: A stall is encoded as `pc_wr_en` = 0, `ifid_wr_en` = 0 and `ctrl_bubble_sel` = 1. With no stall, the encoding is `pc_wr_en` = 1, `ifid_wr_en` = 1 and `ctrl_bubble_sel` = 0. The two enables always agree, and the select is always their complement.
- R6: In a pipeline built around the unit, each load that is immediately followed by an instruction using its nonzero destination costs exactly one stall cycle. Stall cycles never occur back to back. A program of N instructions with S such pairs retires its last instruction N+4+S cycles after the first fetch.
- R7: An injected bubble performs no register write. The number of register writes that retire equals the number of writing instructions in the program.
- R8: After a stall, no instruction is ever in execute while a load writing one of its nonzero source registers is in the memory stage. This leaves forwarding from write-back enough to supply the loaded value.
- R9: Independent instructions, non-load producers, and loads whose consumer is two or more instructions later never cause a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | AW | First source register number of the instruction in decode |
| dec_src_b | input | AW | Second source register number of the instruction in decode |
| exe_dst | input | AW | Destination register number of the instruction in execute |
| exe_mem_rd | input | 1 | Instruction in execute reads data memory (a load) |
| pc_wr_en | output | 1 | Program counter write enable, low during a stall |
| ifid_wr_en | output | 1 | Fetch/decode register write enable, low during a stall |
| ctrl_bubble_sel | output | 1 | Selects an all-zero control bundle into the execute register |

## Verification
Two things can happen in the same cycle. Both decode sources can match a single load, and a stall decision can be made while execute already holds the bubble from the previous stall. The bench provokes the first with directed vectors and with random operands drawn from only eight registers, which often makes both sources equal the destination; such a case must still give one ordinary stall. It provokes the second with chains of loads, each feeding the next, run through a behavioural pipeline. There the bench checks that the bubble in execute never re-arms the stall, counts the stall cycles against the number of adjacent load-use pairs, and checks the retire cycle and the total register writes.

// File: rtl/hzd_pkg.sv
// Package: shared types for the load-use stall unit.
// Assumes: consumers treat the fields as active-high controls.
package hzd_pkg;

    // Front-end control produced by the stall unit
    typedef struct packed {
        logic pc_we;     // program counter may advance
        logic ifid_we;   // fetch/decode register may load
        logic bubble;    // zero the control bundle entering execute
    } hzd_ctrl_t;

    // Control word when the pipeline flows freely
    localparam hzd_ctrl_t HZD_FLOW  = '{pc_we: 1'b1, ifid_we: 1'b1, bubble: 1'b0};
    // Control word when the front end must hold one cycle
    localparam hzd_ctrl_t HZD_HOLD  = '{pc_we: 1'b0, ifid_we: 1'b0, bubble: 1'b1};

endpackage

// File: rtl/hzd_src_cmp.sv
// Module: compares one decode source number with the execute destination.
// Assumes: register 0 is hard-wired to zero when ZERO_REG_FIXED is 1, so a
// write to it is never a real dependency.
module hzd_src_cmp #(
    parameter int AW             = 5,
    parameter bit ZERO_REG_FIXED = 1'b1
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    output logic          hit
);

    logic same;

    // Equality of the two register numbers
    always_comb same = (src == dst);

    generate
        if (ZERO_REG_FIXED) begin : g_zero_fixed
            // Writes to register 0 carry no data, so they never count
            always_comb hit = same && (dst != '0);
        end else begin : g_zero_plain
            // Every register is real, so plain equality decides
            always_comb hit = same;
        end
    endgenerate

endmodule

// File: rtl/hzd_detect.sv
// Module: finds a load-use dependency across all decode sources.
// Assumes: mem_rd marks a load in execute; the other execute-stage producers
// are covered by forwarding and never need a stall.
module hzd_detect #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][AW-1:0] srcs,
    input  logic [AW-1:0]           dst,
    input  logic                    mem_rd,
    output logic                    hazard
);

    logic [NSRC-1:0] hits;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            hzd_src_cmp #(.AW(AW), .ZERO_REG_FIXED(1'b1)) u_cmp (
                .src (srcs[i]),
                .dst (dst),
                .hit (hits[i])
            );
        end
    endgenerate

    // A stall is needed only when a load produces a register that is read
    always_comb hazard = mem_rd && (|hits);

endmodule

// File: rtl/hzd_ctrl_gen.sv
// Module: turns the hazard flag into the front-end control word.
// Assumes: one hold cycle is enough because the load leaves execute on the
// next edge and a bubble takes its place.
module hzd_ctrl_gen
    import hzd_pkg::*;
(
    input  logic      hazard,
    output hzd_ctrl_t ctl
);

    // Choose between the freeze word and the free-flow word
    always_comb ctl = hazard ? HZD_HOLD : HZD_FLOW;

endmodule

// File: rtl/hzd_load_use_unit.sv
// Module: top of the load-use stall unit in the decode stage.
// Purpose: holds the PC and the fetch/decode register and requests a zeroed
// control bundle whenever decode reads a register that a load in execute
// has not yet returned.
// Assumes: the datapath applies ctrl_bubble_sel at the input of the execute
// register, and forwarding covers every other dependency. The unit is
// combinational and holds no state.
module hzd_load_use_unit
    import hzd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] dec_src_a,
    input  logic [AW-1:0] dec_src_b,
    input  logic [AW-1:0] exe_dst,
    input  logic          exe_mem_rd,
    output logic          pc_wr_en,
    output logic          ifid_wr_en,
    output logic          ctrl_bubble_sel
);

    localparam int NSRC = 2;

    logic [NSRC-1:0][AW-1:0] srcs;
    logic                    hazard;
    hzd_ctrl_t               ctl;

    // Gather the decode source numbers into one vector
    always_comb srcs = {dec_src_b, dec_src_a};

    hzd_detect #(.AW(AW), .NSRC(NSRC)) u_detect (
        .srcs   (srcs),
        .dst    (exe_dst),
        .mem_rd (exe_mem_rd),
        .hazard (hazard)
    );

    hzd_ctrl_gen u_ctrl (
        .hazard (hazard),
        .ctl    (ctl)
    );

    // Drive the three front-end controls from the control word
    always_comb begin
        pc_wr_en        = ctl.pc_we;
        ifid_wr_en      = ctl.ifid_we;
        ctrl_bubble_sel = ctl.bubble;
    end

endmodule

// File: rtl/hzd_load_use_chk.sv
// Module: assertion checker for the load-use stall unit, bound to the top.
// Assumes: checks apply only once every input is driven to a known value.
module hzd_load_use_chk #(
    parameter int AW = 5
) (
    input logic [AW-1:0] dec_src_a,
    input logic [AW-1:0] dec_src_b,
    input logic [AW-1:0] exe_dst,
    input logic          exe_mem_rd,
    input logic          pc_wr_en,
    input logic          ifid_wr_en,
    input logic          ctrl_bubble_sel
);

    logic known;

    // Skip checking while any port is still undriven
    always_comb known = !$isunknown({dec_src_a, dec_src_b, exe_dst, exe_mem_rd,
                                     pc_wr_en, ifid_wr_en, ctrl_bubble_sel});

    // Port-level relations between the inputs and the three controls
    always_comb begin
        if (known) begin
            a_r1_stall_on_src_a: assert (!(exe_mem_rd && exe_dst != '0 &&
                                           exe_dst == dec_src_a) || ctrl_bubble_sel)
                else $error("R1: load-use on source a without a stall");
            a_r2_stall_on_src_b: assert (!(exe_mem_rd && exe_dst != '0 &&
                                           exe_dst == dec_src_b) || ctrl_bubble_sel)
                else $error("R2: load-use on source b without a stall");
            a_r3_zero_dest_free: assert (exe_dst != '0 || pc_wr_en)
                else $error("R3: stall for a write to register 0");
            a_r4_non_load_free: assert (exe_mem_rd || pc_wr_en)
                else $error("R4: stall without a load in execute");
            a_r5_enables_agree: assert ((pc_wr_en == ifid_wr_en) &&
                                        (ctrl_bubble_sel != pc_wr_en))
                else $error("R5: front-end controls disagree");
            a_r9_no_match_free: assert (exe_dst == dec_src_a || exe_dst == dec_src_b ||
                                        !ctrl_bubble_sel)
                else $error("R9: stall with no register match");
        end
    end

endmodule

bind hzd_load_use_unit hzd_load_use_chk #(.AW(AW)) u_chk (
    .dec_src_a       (dec_src_a),
    .dec_src_b       (dec_src_b),
    .exe_dst         (exe_dst),
    .exe_mem_rd      (exe_mem_rd),
    .pc_wr_en        (pc_wr_en),
    .ifid_wr_en      (ifid_wr_en),
    .ctrl_bubble_sel (ctrl_bubble_sel)
);

// File: tb/sim_hzd_load_use_unit.sv
module sim_hzd_load_use_unit;

    localparam int CLK_P = 10;
    localparam int AW    = 5;
    localparam int PMAX  = 64;

    typedef struct packed {
        logic          vld;
        logic          ld;
        logic          wr;
        logic [AW-1:0] dst;
        logic [AW-1:0] s1;
        logic [AW-1:0] s2;
    } ins_t;

    logic          clk = 1'b0;
    logic [AW-1:0] dec_src_a = '0;
    logic [AW-1:0] dec_src_b = '0;
    logic [AW-1:0] exe_dst = '0;
    logic          exe_mem_rd = 1'b0;
    logic          pc_wr_en, ifid_wr_en, ctrl_bubble_sel;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    ins_t prog [PMAX];
    int   plen;

    always #(CLK_P/2) clk = ~clk;

    hzd_load_use_unit #(.AW(AW)) u0 (
        .dec_src_a       (dec_src_a),
        .dec_src_b       (dec_src_b),
        .exe_dst         (exe_dst),
        .exe_mem_rd      (exe_mem_rd),
        .pc_wr_en        (pc_wr_en),
        .ifid_wr_en      (ifid_wr_en),
        .ctrl_bubble_sel (ctrl_bubble_sel)
    );

    // Expected stall from the requirement text
    function automatic bit exp_stall(logic ld, logic [AW-1:0] d,
                                     logic [AW-1:0] a, logic [AW-1:0] b);
        return ld && (d != '0) && (d == a || d == b);
    endfunction

    // Requirement tag that governs a given port pattern
    function automatic string tag_of(logic ld, logic [AW-1:0] d,
                                     logic [AW-1:0] a, logic [AW-1:0] b);
        if (!ld) return "R4";
        if (d == '0) return "R3";
        if (d == a) return "R1";
        if (d == b) return "R2";
        return "R9";
    endfunction

    task automatic chk(input string rq, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Check all outputs against the current port inputs
    task automatic port_check();
        bit e;
        e = exp_stall(exe_mem_rd, exe_dst, dec_src_a, dec_src_b);
        chk(tag_of(exe_mem_rd, exe_dst, dec_src_a, dec_src_b), int'(ctrl_bubble_sel), int'(e));
        chk("R5", int'({pc_wr_en, ifid_wr_en}), e ? 0 : 3);
    endtask

    task automatic apply(input logic ld, input logic [AW-1:0] d,
                         input logic [AW-1:0] a, input logic [AW-1:0] b);
        @(posedge clk);
        exe_mem_rd = ld; exe_dst = d; dec_src_a = a; dec_src_b = b;
        @(negedge clk);
        port_check();
    endtask

    function automatic ins_t mk(logic ld, logic wr, int d, int a, int b);
        ins_t t;
        t.vld = 1'b1; t.ld = ld; t.wr = wr;
        t.dst = AW'(d); t.s1 = AW'(a); t.s2 = AW'(b);
        return t;
    endfunction

    // Number of adjacent load-use pairs in the loaded program
    function automatic int exp_pairs();
        int s = 0;
        for (int i = 0; i + 1 < plen; i++)
            if (exp_stall(prog[i].ld, prog[i].dst, prog[i+1].s1, prog[i+1].s2)) s++;
        return s;
    endfunction

    function automatic int exp_writes();
        int w = 0;
        for (int i = 0; i < plen; i++) if (prog[i].wr) w++;
        return w;
    endfunction

    // Run the loaded program through a behavioural five-stage pipeline
    task automatic run_prog(input string name);
        ins_t ifid, idex, exmem, memwb, f;
        int pc, cyc, retired, writes, stalls, done_cyc, s_exp;
        bit prev_stall;
        ifid = '0; idex = '0; exmem = '0; memwb = '0;
        pc = 0; retired = 0; writes = 0; stalls = 0; done_cyc = 0;
        prev_stall = 1'b0;
        s_exp = exp_pairs();
        for (cyc = 1; cyc < 4 * PMAX + 20 && retired < plen; cyc++) begin
            @(posedge clk);
            exe_mem_rd = idex.ld; exe_dst = idex.dst;
            dec_src_a = ifid.s1; dec_src_b = ifid.s2;
            @(negedge clk);
            port_check();
            if (ctrl_bubble_sel && prev_stall) chk("R6", 1, 0);
            if (idex.vld && exmem.ld && exmem.dst != '0 &&
                (exmem.dst == idex.s1 || exmem.dst == idex.s2)) chk("R8", 1, 0);
            if (memwb.vld) retired++;
            if (memwb.wr) writes++;
            if (retired == plen) done_cyc = cyc;
            if (ctrl_bubble_sel) stalls++;
            prev_stall = ctrl_bubble_sel;
            memwb = exmem;
            exmem = idex;
            idex  = ifid;
            if (ctrl_bubble_sel) begin idex.vld = 0; idex.ld = 0; idex.wr = 0; end
            f = (pc < plen) ? prog[pc] : '0;
            if (ifid_wr_en) ifid = f;
            if (pc_wr_en) pc++;
        end
        chk("R6", stalls, s_exp);
        chk("R6", done_cyc, plen + 4 + s_exp);
        chk("R7", writes, exp_writes());
        if (n_bad != 0) $display("  after program %s", name);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5a_7c01));
        // Idle state: nothing in flight, front end must flow (R5)
        @(negedge clk);
        chk("R5", int'({pc_wr_en, ifid_wr_en, ctrl_bubble_sel}), 6);
        // Directed port corners
        apply(1, 3, 3, 7);    // R1
        apply(1, 4, 9, 4);    // R2
        apply(1, 6, 6, 6);    // R1 both sources match
        apply(1, 0, 0, 0);    // R3
        apply(0, 5, 5, 5);    // R4
        apply(1, 8, 1, 2);    // R9
        apply(1, 31, 31, 0);  // R1 top register
        // Random port vectors with a small register range
        for (int i = 0; i < 3000; i++)
            apply(1'($urandom), AW'($urandom % 8), AW'($urandom % 8), AW'($urandom % 8));

        // Program: load then immediate use on each source (R1, R2, R6)
        plen = 4;
        prog[0] = mk(1, 1, 2, 0, 0); prog[1] = mk(0, 1, 3, 2, 1);
        prog[2] = mk(1, 1, 4, 0, 0); prog[3] = mk(0, 1, 5, 1, 4);
        run_prog("use_each_src");
        // Program: load to r0, non-load producer, distance-two use (R3, R4, R9)
        plen = 5;
        prog[0] = mk(1, 1, 0, 1, 1); prog[1] = mk(0, 1, 6, 0, 0);
        prog[2] = mk(0, 1, 7, 6, 6); prog[3] = mk(1, 1, 8, 0, 0);
        prog[4] = mk(0, 0, 0, 1, 1); // independent, then distance two below
        plen = 6; prog[5] = mk(0, 1, 9, 8, 0);
        run_prog("no_stall_mix");
        // Program: chain of loads, each feeding the next (R6, R8)
        plen = 6;
        for (int i = 0; i < 6; i++) prog[i] = mk(1, 1, i + 1, i, i);
        run_prog("load_chain");
        // Random programs
        for (int p = 0; p < 40; p++) begin
            plen = 24;
            for (int i = 0; i < plen; i++) begin
                bit ld;
                ld = ($urandom % 3) == 0;
                prog[i] = mk(ld, ld | 1'($urandom % 4 != 0), $urandom % 8,
                             $urandom % 8, $urandom % 8);
            end
            run_prog("random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule